// File: doc/BRIEF.md
# Single-Wire Bus Slave with Network Addressing

This block is the slave end of a single-wire, open-drain bus. The bus master drives all timing by pulling the shared line low. The block oversamples the line on a one-microsecond tick and recognises three things: a long low as a bus reset, a short low as a bit slot, and the point in each slot at which it samples or drives the line. After each bus reset it answers with a presence pulse.

On top of the slot layer sits the 64-bit network-address layer. The address ROM is built at elaboration from a family byte, a 48-bit serial number and an 8-bit CRC, and is sent least significant bit first. The master can read the address, select the device by match or skip, single it out bit by bit with the search triplet, or run a swap hand-off. In a swap, a trailing timing pulse raises a power-off request and then a power-on request in the device that matched.

Once addressing succeeds, every further group of eight written bits is passed downstream as one byte, least significant bit first, with a one-cycle strobe. A failed match, a search drop-out, an unknown opcode or an aborted slot parks the block until the next bus reset.

Top module: `swb_slave_addr`

## Requirements
- R1: A low of at least 480 ticks followed by a release is a bus reset. 30 ticks after the release the block pulls the line low for 120 ticks (presence), then releases it.
- R2: A write slot is sampled 30 ticks after its falling edge is seen (line high = 1). Bytes written after a skip (opcode CCh) come out on `fn_data`, least significant bit first, with `fn_strobe` high for one cycle per byte.
- R3: Read-address uses opcode 33h when `rd_opcode_alt` is 0 and 39h when it is 1. The other of the two is treated as unknown. The block answers 64 read slots with address bits 0..63: bits 7:0 are the family byte 30h, bits 55:8 the serial and bits 63:56 the CRC. For a 0 it holds the line low from the falling edge for 35 ticks.
- R4: The CRC is x^8+x^5+x^4+1 over address bits 0..55, shifted least significant bit first from an initial value of zero.
- R5: Match (55h) followed by 64 written bits equal to the address selects the device, and later bytes are delivered. On any differing bit the block stops, delivers no bytes and drives no read slot until the next bus reset.
- R6: Search (F0h) runs 64 triplets. In each, the block sends address bit i, then its complement, then samples the master's bit. After 64 agreeing triplets, later bytes are delivered.
- R7: If the master's bit in a search triplet differs from address bit i, the block drops out. It drives no further slots and delivers no bytes until the next bus reset.
- R8: With `swap_en` = 1, swap (AAh) clears both power requests and is followed by 64 match bits. On the next falling edge `pwr_off_req` rises. On the rising edge that follows, a matched device clears `pwr_off_req` and sets `pwr_on_req`, while an unmatched device keeps `pwr_off_req` = 1 and `pwr_on_req` = 0.
- R9: With `swap_en` = 0, AAh is ignored: the power requests do not change and no bytes are delivered until a bus reset.
- R10: A low lasting more than 120 ticks but less than 480 ticks aborts the transaction. No bytes are delivered until the next bus reset.
- R11: An opcode other than the selected read opcode, 55h, CCh, F0h or an enabled AAh is ignored until the next bus reset.
- R12: After `rst`, the line is released, `fn_strobe`, `pwr_off_req` and `pwr_on_req` are 0, and slots are ignored until the first bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| line_in | input | 1 | Sensed level of the bus line |
| line_pull_low | output | 1 | 1 = open-drain driver pulls the line low |
| rd_opcode_alt | input | 1 | 0: read opcode 33h, 1: read opcode 39h |
| swap_en | input | 1 | Enables recognition of the swap opcode |
| fn_data | output | 8 | Function byte received after addressing |
| fn_strobe | output | 1 | One-cycle strobe for `fn_data` |
| pwr_off_req | output | 1 | Power-off request from the swap pulse |
| pwr_on_req | output | 1 | Power-on request in the matched device |

## Verification
The bench targets the points where a slave most easily goes wrong.

- **Opcode select.** It reads the address under both settings of the opcode select. A design that honoured both opcodes would drive data where the bench expects a released line.
- **Last-bit mismatch.** It puts the mismatch on the last match bit, and at random positions, to catch a design that decides too early or only checks part of the address. Such a design would still deliver bytes.
- **Search drop-out.** It drops out of a search at a random triplet. A design that keeps going would keep driving read slots.
- **Swap.** It runs swap with a matching address, with a wrong address and with swap disabled. A wrong hand-off would show a power-on request in the wrong device or a request change that should not happen.
- **Abort.** A mid-length low that aborts the transaction must stop byte delivery.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SLOT,
    PH_PWAIT,
    PH_PDRV
  } phy_state_t;

  typedef enum logic [3:0] {
    ST_IGNORE,
    ST_CMD,
    ST_RD_ADDR,
    ST_MATCH,
    ST_FUNC,
    ST_SRCH_BIT,
    ST_SRCH_CMP,
    ST_SRCH_DIR,
    ST_SWAP_MATCH,
    ST_SWAP_PULSE
  } net_state_t;

  localparam logic [7:0] OP_READ_A = 8'h33;
  localparam logic [7:0] OP_READ_B = 8'h39;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_SWAP   = 8'hAA;

endpackage

// File: rtl/swb_addr_rom.sv
module swb_addr_rom #(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter logic [FAM_W-1:0] FAMILY = 8'h30,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_0000_0001,
  parameter int ADDR_BITS = FAM_W + SER_W + 8,
  parameter int IDX_W = $clog2(ADDR_BITS)
) (
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  localparam int BODY_W = FAM_W + SER_W;

  // Reflected form of x^8+x^5+x^4+1, LSB first, zero seed
  function automatic logic [7:0] crc_body(input logic [BODY_W-1:0] body);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb = c[0] ^ body[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  localparam logic [BODY_W-1:0]    BODY = {SERIAL, FAMILY};
  localparam logic [7:0]           CRC  = crc_body(BODY);
  localparam logic [ADDR_BITS-1:0] ROM  = {CRC, BODY};

  assign bit_o = ROM[idx];
endmodule

// File: rtl/swb_line_phy.sv
module swb_line_phy #(
  parameter int RST_T     = 480,
  parameter int ABORT_T   = 120,
  parameter int SAMPLE_T  = 30,
  parameter int HOLD_T    = 35,
  parameter int PRES_WAIT = 30,
  parameter int PRES_LEN  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_in,
  input  logic rd_mode,
  input  logic rd_bit,
  output logic pull_low,
  output logic slot_done,
  output logic slot_bit,
  output logic bus_reset,
  output logic bus_abort,
  output logic fall_evt,
  output logic rise_evt
);
  import swb_pkg::*;

  localparam int CW = $clog2(RST_T + 1) + 1;
  localparam logic [CW-1:0] C_RST   = CW'(RST_T);
  localparam logic [CW-1:0] C_ABORT = CW'(ABORT_T + 1);
  localparam logic [CW-1:0] C_SAMP  = CW'(SAMPLE_T);
  localparam logic [CW-1:0] C_HOLD  = CW'(HOLD_T);
  localparam logic [CW-1:0] C_PWAIT = CW'(PRES_WAIT - 1);
  localparam logic [CW-1:0] C_PLEN  = CW'(PRES_LEN - 1);
  localparam logic [CW-1:0] C_MAX   = '1;

  phy_state_t    st;
  logic [CW-1:0] cnt;
  logic [2:0]    sync;
  logic          cur, prev;

  assign cur  = sync[1];
  assign prev = sync[2];

  always_ff @(posedge clk) begin
    if (rst) sync <= 3'b111;
    else     sync <= {sync[1:0], line_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      pull_low  <= 1'b0;
      slot_done <= 1'b0;
      slot_bit  <= 1'b1;
      bus_reset <= 1'b0;
      bus_abort <= 1'b0;
      fall_evt  <= 1'b0;
      rise_evt  <= 1'b0;
    end else begin
      slot_done <= 1'b0;
      bus_reset <= 1'b0;
      bus_abort <= 1'b0;
      fall_evt  <= 1'b0;
      rise_evt  <= ~prev & cur;
      case (st)
        PH_IDLE: begin
          if (prev && !cur) begin
            st       <= PH_SLOT;
            cnt      <= '0;
            fall_evt <= 1'b1;
            pull_low <= rd_mode & ~rd_bit;
          end
        end
        PH_SLOT: begin
          if (tick) begin
            if (cnt != C_MAX) cnt <= cnt + 1'b1;
            if (cnt == C_SAMP) begin
              slot_done <= 1'b1;
              slot_bit  <= cur;
            end
            if (cnt == C_HOLD) pull_low <= 1'b0;
            if (!cur && cnt == C_ABORT) bus_abort <= 1'b1;
          end
          if (cur && cnt > C_SAMP) begin
            if (cnt >= C_RST) begin
              bus_reset <= 1'b1;
              st        <= PH_PWAIT;
              cnt       <= '0;
            end else begin
              st <= PH_IDLE;
            end
          end
        end
        PH_PWAIT: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == C_PWAIT) begin
              st       <= PH_PDRV;
              cnt      <= '0;
              pull_low <= 1'b1;
            end
          end
        end
        PH_PDRV: begin
          if (tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == C_PLEN) begin
              pull_low <= 1'b0;
              st       <= PH_IDLE;
            end
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assert_drive_window_R3: assert property (@(posedge clk) disable iff (rst)
    (pull_low && st == PH_SLOT) |-> (cnt <= C_HOLD));

  assert_presence_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(st == PH_PDRV) |-> ($past(st) == PH_PWAIT));

endmodule

// File: rtl/swb_net_proto.sv
module swb_net_proto #(
  parameter int ADDR_BITS = 64,
  parameter int IDX_W = $clog2(ADDR_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_done,
  input  logic             slot_bit,
  input  logic             bus_reset,
  input  logic             bus_abort,
  input  logic             fall_evt,
  input  logic             rise_evt,
  input  logic             rd_opcode_alt,
  input  logic             swap_en,
  input  logic             addr_bit,
  output logic [IDX_W-1:0] addr_idx,
  output logic             rd_mode,
  output logic             rd_bit,
  output logic [7:0]       fn_data,
  output logic             fn_strobe,
  output logic             pwr_off_req,
  output logic             pwr_on_req
);
  import swb_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ADDR_BITS - 1);

  net_state_t       st;
  logic [IDX_W-1:0] idx;
  logic [7:0]       shreg, nxt, read_op;
  logic [2:0]       nbits;
  logic             swap_miss, seen_fall;

  assign nxt      = {slot_bit, shreg[7:1]};
  assign read_op  = rd_opcode_alt ? OP_READ_B : OP_READ_A;
  assign addr_idx = idx;

  always_comb begin
    rd_mode = (st == ST_RD_ADDR) || (st == ST_SRCH_BIT) || (st == ST_SRCH_CMP);
    rd_bit  = (st == ST_SRCH_CMP) ? ~addr_bit : addr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IGNORE;
      idx         <= '0;
      shreg       <= '0;
      nbits       <= '0;
      fn_data     <= '0;
      fn_strobe   <= 1'b0;
      pwr_off_req <= 1'b0;
      pwr_on_req  <= 1'b0;
      swap_miss   <= 1'b0;
      seen_fall   <= 1'b0;
    end else begin
      fn_strobe <= 1'b0;
      if (bus_reset) begin
        st    <= ST_CMD;
        idx   <= '0;
        nbits <= '0;
      end else if (bus_abort) begin
        st <= ST_IGNORE;
      end else begin
        case (st)
          ST_CMD: if (slot_done) begin
            shreg <= nxt;
            nbits <= nbits + 1'b1;
            if (nbits == 3'd7) begin
              idx <= '0;
              if (nxt == read_op)                 st <= ST_RD_ADDR;
              else if (nxt == OP_MATCH)           st <= ST_MATCH;
              else if (nxt == OP_SKIP)            st <= ST_FUNC;
              else if (nxt == OP_SEARCH)          st <= ST_SRCH_BIT;
              else if (nxt == OP_SWAP && swap_en) begin
                st          <= ST_SWAP_MATCH;
                pwr_off_req <= 1'b0;
                pwr_on_req  <= 1'b0;
                swap_miss   <= 1'b0;
              end else                            st <= ST_IGNORE;
            end
          end
          ST_RD_ADDR: if (slot_done) begin
            if (idx == LAST) st <= ST_IGNORE;
            else             idx <= idx + 1'b1;
          end
          ST_MATCH: if (slot_done) begin
            if (slot_bit != addr_bit) st <= ST_IGNORE;
            else if (idx == LAST)     st <= ST_FUNC;
            else                      idx <= idx + 1'b1;
          end
          ST_FUNC: if (slot_done) begin
            shreg <= nxt;
            nbits <= nbits + 1'b1;
            if (nbits == 3'd7) begin
              fn_data   <= nxt;
              fn_strobe <= 1'b1;
            end
          end
          ST_SRCH_BIT: if (slot_done) st <= ST_SRCH_CMP;
          ST_SRCH_CMP: if (slot_done) st <= ST_SRCH_DIR;
          ST_SRCH_DIR: if (slot_done) begin
            if (slot_bit != addr_bit) st <= ST_IGNORE;
            else if (idx == LAST)     st <= ST_FUNC;
            else begin
              idx <= idx + 1'b1;
              st  <= ST_SRCH_BIT;
            end
          end
          ST_SWAP_MATCH: if (slot_done) begin
            swap_miss <= swap_miss | (slot_bit != addr_bit);
            if (idx == LAST) begin
              st        <= ST_SWAP_PULSE;
              seen_fall <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_SWAP_PULSE: begin
            if (fall_evt) begin
              pwr_off_req <= 1'b1;
              seen_fall   <= 1'b1;
            end else if (rise_evt && seen_fall) begin
              if (!swap_miss) begin
                pwr_off_req <= 1'b0;
                pwr_on_req  <= 1'b1;
              end
              st <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    fn_strobe |=> !fn_strobe);

  assert_ignore_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE && !bus_reset) |=> (st == ST_IGNORE));

  assert_pwr_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(pwr_off_req && pwr_on_req));

  assert_search_order_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SRCH_DIR) |-> ($past(st) == ST_SRCH_DIR || $past(st) == ST_SRCH_CMP));

endmodule

// File: rtl/swb_slave_addr.sv
module swb_slave_addr #(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter logic [FAM_W-1:0] FAMILY = 8'h30,
  parameter logic [SER_W-1:0] SERIAL = 48'hA5C3_1E07_9B42,
  parameter int RST_T     = 480,
  parameter int ABORT_T   = 120,
  parameter int SAMPLE_T  = 30,
  parameter int HOLD_T    = 35,
  parameter int PRES_WAIT = 30,
  parameter int PRES_LEN  = 120
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_us,
  input  logic       line_in,
  output logic       line_pull_low,
  input  logic       rd_opcode_alt,
  input  logic       swap_en,
  output logic [7:0] fn_data,
  output logic       fn_strobe,
  output logic       pwr_off_req,
  output logic       pwr_on_req
);
  localparam int ADDR_BITS = FAM_W + SER_W + 8;
  localparam int IDX_W     = $clog2(ADDR_BITS);

  logic             slot_done, slot_bit, bus_reset, bus_abort, fall_evt, rise_evt;
  logic             rd_mode, rd_bit, addr_bit;
  logic [IDX_W-1:0] addr_idx;

  swb_line_phy #(
    .RST_T(RST_T), .ABORT_T(ABORT_T), .SAMPLE_T(SAMPLE_T),
    .HOLD_T(HOLD_T), .PRES_WAIT(PRES_WAIT), .PRES_LEN(PRES_LEN)
  ) u_phy (
    .clk(clk), .rst(rst), .tick(tick_us), .line_in(line_in),
    .rd_mode(rd_mode), .rd_bit(rd_bit), .pull_low(line_pull_low),
    .slot_done(slot_done), .slot_bit(slot_bit), .bus_reset(bus_reset),
    .bus_abort(bus_abort), .fall_evt(fall_evt), .rise_evt(rise_evt)
  );

  swb_addr_rom #(
    .FAM_W(FAM_W), .SER_W(SER_W), .FAMILY(FAMILY), .SERIAL(SERIAL),
    .ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)
  ) u_rom (
    .idx(addr_idx), .bit_o(addr_bit)
  );

  swb_net_proto #(
    .ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)
  ) u_net (
    .clk(clk), .rst(rst), .slot_done(slot_done), .slot_bit(slot_bit),
    .bus_reset(bus_reset), .bus_abort(bus_abort), .fall_evt(fall_evt),
    .rise_evt(rise_evt), .rd_opcode_alt(rd_opcode_alt), .swap_en(swap_en),
    .addr_bit(addr_bit), .addr_idx(addr_idx), .rd_mode(rd_mode),
    .rd_bit(rd_bit), .fn_data(fn_data), .fn_strobe(fn_strobe),
    .pwr_off_req(pwr_off_req), .pwr_on_req(pwr_on_req)
  );
endmodule

// File: tb/tb_swb_slave_addr.sv
module tb_swb_slave_addr;
  localparam logic [7:0]  FAM = 8'h30;
  localparam logic [47:0] SER = 48'hA5C3_1E07_9B42;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, m_low = 1'b0;
  logic alt = 1'b0, swen = 1'b0;
  logic pull, fns, poff, pon;
  logic [7:0] fnd;
  logic dq;
  assign dq = ~(m_low | pull);

  always #2 clk = ~clk;   // 250 MHz, one tick per clock

  swb_slave_addr #(.FAMILY(FAM), .SERIAL(SER)) dut (
    .clk(clk), .rst(rst), .tick_us(tick), .line_in(dq), .line_pull_low(pull),
    .rd_opcode_alt(alt), .swap_en(swen), .fn_data(fnd), .fn_strobe(fns),
    .pwr_off_req(poff), .pwr_on_req(pon)
  );

  int n_chk = 0, n_bad = 0, n_strobe = 0;
  logic [7:0] last_byte = '0;
  bit done = 0;

  always @(negedge clk) if (!rst && fns) begin
    n_strobe++;
    last_byte = fnd;
  end

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 56; i++) begin
      logic in_b = c[0] ^ d[i];
      c = {in_b, c[7:1]};
      c[3] = c[3] ^ in_b;   // x^4 term
      c[2] = c[2] ^ in_b;   // x^5 term
    end
    return c;
  endfunction

  function automatic logic [63:0] ref_addr();
    return {ref_crc({SER, FAM}), SER, FAM};
  endfunction

  task automatic wt(input int n); #(n * 4); endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wbit(input logic b);
    m_low = 1'b1; wt(b ? 5 : 65);
    m_low = 1'b0; wt(b ? 65 : 5);
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b1; wt(6);
    m_low = 1'b0; wt(9);
    b = dq;
    wt(55);
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wbit(v[i]);
  endtask

  task automatic w64(input logic [63:0] v);
    for (int i = 0; i < 64; i++) wbit(v[i]);
  endtask

  task automatic r64(output logic [63:0] v);
    logic b;
    for (int i = 0; i < 64; i++) begin rbit(b); v[i] = b; end
  endtask

  task automatic breset();
    m_low = 1'b1; wt(500);
    m_low = 1'b0; wt(60);
    chk(dq == 1'b0, "R1 presence low", dq, 0);
    wt(150);
    chk(dq == 1'b1, "R1 presence released", dq, 1);
    wt(10);
  endtask

  task automatic byte_expect(input logic [7:0] v, input bit deliver, input string req);
    int s0 = n_strobe;
    wbyte(v);
    wt(2);
    if (deliver) chk(n_strobe == s0 + 1 && last_byte == v, req, last_byte, v);
    else         chk(n_strobe == s0, req, n_strobe - s0, 0);
  endtask

  task automatic swap_pulse(input logic e_off_lo, input logic e_on_lo,
                            input logic e_off_hi, input logic e_on_hi, input string req);
    wt(10);
    m_low = 1'b1; wt(80);
    chk(poff == e_off_lo && pon == e_on_lo, req, {poff, pon}, {e_off_lo, e_on_lo});
    m_low = 1'b0; wt(20);
    chk(poff == e_off_hi && pon == e_on_hi, req, {poff, pon}, {e_off_hi, e_on_hi});
  endtask

  initial begin
    #(190000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ea, got;
    logic b, c;
    logic [7:0] rb, op;
    int k, errs;
    void'($urandom(32'd2024));
    ea = ref_addr();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wt(2);

    // R12: reset state and no slot handling before the first bus reset
    chk(pull == 0 && fns == 0 && poff == 0 && pon == 0, "R12 reset state",
        {pull, fns, poff, pon}, 0);
    wbyte(8'hCC);
    byte_expect(8'h5A, 0, "R12 slots before bus reset");

    // R3 / R4: read address with both opcode selections
    breset(); wbyte(8'h33); r64(got);
    chk(got == ea, "R3 read address 33h", got, ea);
    chk(got[7:0] == 8'h30, "R3 family byte", got[7:0], 8'h30);
    chk(got[63:56] == ref_crc(got[55:0]), "R4 crc byte", got[63:56], ref_crc(got[55:0]));
    breset(); wbyte(8'h39); r64(got);
    chk(got == '1, "R3 39h ignored when select=0", got, '1);
    alt = 1'b1;
    breset(); wbyte(8'h39); r64(got);
    chk(got == ea, "R3 read address 39h", got, ea);
    breset(); wbyte(8'h33); rbit(b);
    chk(b == 1'b1, "R3 33h ignored when select=1", b, 1);
    alt = 1'b0;

    // R2: skip, then directed and random bytes
    breset(); wbyte(8'hCC);
    byte_expect(8'h00, 1, "R2 byte 00");
    byte_expect(8'hFF, 1, "R2 byte FF");
    for (int i = 0; i < 4; i++) begin
      rb = 8'($urandom);
      byte_expect(rb, 1, "R2 random byte");
    end

    // R5: matching address, then mismatches at first, last and random bit
    breset(); wbyte(8'h55); w64(ea);
    byte_expect(8'($urandom), 1, "R5 match delivers");
    for (int t = 0; t < 3; t++) begin
      k = (t == 0) ? 0 : (t == 1) ? 63 : int'($urandom_range(1, 62));
      breset(); wbyte(8'h55); w64(ea ^ (64'd1 << k));
      byte_expect(8'hA3, 0, "R5 mismatch blocks bytes");
      rbit(b);
      chk(b == 1'b1, "R5 mismatch no drive", b, 1);
    end

    // R6: full search
    breset(); wbyte(8'hF0); errs = 0;
    for (int i = 0; i < 64; i++) begin
      rbit(b); rbit(c);
      if (b != ea[i] || c != ~ea[i]) errs++;
      wbit(ea[i]);
    end
    chk(errs == 0, "R6 search triplets", errs, 0);
    byte_expect(8'h3C, 1, "R6 search selects");

    // R7: search drop-out at a random bit
    k = int'($urandom_range(0, 63));
    breset(); wbyte(8'hF0);
    for (int i = 0; i < k; i++) begin
      rbit(b); rbit(c); wbit(ea[i]);
    end
    rbit(b); rbit(c); wbit(~ea[k]);
    rbit(b); rbit(c);
    chk(b == 1'b1 && c == 1'b1, "R7 dropout no drive", {b, c}, 2'b11);
    byte_expect(8'h81, 0, "R7 dropout no bytes");

    // R8: swap with matching and with wrong address
    swen = 1'b1;
    breset(); wbyte(8'hAA); w64(ea);
    swap_pulse(1, 0, 0, 1, "R8 matched swap");
    breset(); wbyte(8'hAA);
    chk(poff == 0 && pon == 0, "R8 swap clears requests", {poff, pon}, 0);
    w64(ea ^ (64'd1 << $urandom_range(0, 63)));
    swap_pulse(1, 0, 1, 0, "R8 unmatched swap");

    // R9: swap disabled
    swen = 1'b0;
    breset(); wbyte(8'hAA); w64(ea);
    swap_pulse(1, 0, 1, 0, "R9 swap disabled");
    byte_expect(8'h42, 0, "R9 swap disabled no bytes");

    // R10: abort by a mid-length low
    breset(); wbyte(8'hCC);
    byte_expect(8'h96, 1, "R10 before abort");
    m_low = 1'b1; wt(200); m_low = 1'b0; wt(20);
    byte_expect(8'h69, 0, "R10 after abort");
    breset(); wbyte(8'hCC);
    byte_expect(8'h69, 1, "R10 recovers after reset");

    // R11: unknown opcode
    do op = 8'($urandom);
    while (op == 8'h33 || op == 8'h39 || op == 8'h55 || op == 8'hCC ||
           op == 8'hF0 || op == 8'hAA);
    breset(); wbyte(op);
    rbit(b);
    chk(b == 1'b1, "R11 unknown opcode no drive", b, 1);
    byte_expect(8'h5A, 0, "R11 unknown opcode no bytes");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule